// File: doc/BRIEF.md
# Strobed Serial Command Decoder

This block is the host-facing serial port of a multiplexed LED display controller. A host frames each transaction with an active-low strobe. It shifts bytes in over a data line, least significant bit first, and each bit is taken on a rising edge of the serial clock. The block oversamples the serial clock, strobe and data in its own system clock domain. It treats the first complete byte of every frame as a command and handles any later bytes as display data or discards them, depending on that command.

There are four command classes, selected by the top two bits of the command byte:
- **Grid-mode selection** sets how many digits are scanned.
- **Transfer setting** holds a configuration nibble and chooses the key-read direction.
- **Address load** sets the display RAM pointer.
- **Display control** turns the display on or off and picks one of eight dimming steps.

Data bytes go into a 14-byte display RAM at an auto-incrementing pointer. The pointer stops at the window edge. The scanner reads the RAM through a combinational read port and reads the grid mode, on/off and dimming registers directly. A key-read request comes out as a single-cycle flag; the key data transfer itself belongs to another block.

Top module: `strobe_cmd_decoder`

## Requirements
- R1: A bit is captured only on a rising serial-clock edge while the strobe is low, and bits are assembled least significant first. Serial-clock edges while the strobe is high have no effect.
- R2: The first complete byte after the strobe falls is decoded as a command. Later bytes in that frame are written to the RAM only when the command was an address load or a write-direction transfer setting; otherwise they are ignored.
- R3: Releasing the strobe before a byte completes discards the partial byte. The next frame starts again at bit 0, with its first byte taken as a command.
- R4: Command `000000mm` sets `grid_mode` to mm, where the grid count is 4 + mm.
- R5: A grid-mode command that changes the mode forces the display off. Re-issuing the current mode changes nothing, including the on/off state.
- R6: Command `0100cccc` loads `data_cfg` with cccc.
- R7: Command `11aaaaaa` loads the 6-bit RAM pointer. Each following data byte is written at the pointer, which then increments, so up to 14 bytes per frame land at consecutive addresses.
- R8: While the pointer is 14 or higher, data bytes are dropped and the pointer holds until an address load brings it back into range.
- R9: Command `10xxoddd` sets `disp_on` to o and `dim_level` to ddd. Byte 80h turns the display off at the lowest dimming step.
- R10: A transfer setting with bit 1 set pulses `key_rd_req` for exactly one cycle, and the remaining bytes of that frame are not written.
- R11: After reset: `grid_mode` is 3, `disp_on` is 0, `dim_level` is 0, `data_cfg` is 0, the pointer is 0 and every RAM byte is 0.
- R12: A command with class bits 00 and any of bits 5..2 set, or with class bits 01 and any of bits 5..4 set, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_stb_n | input | 1 | Active-low frame strobe |
| ser_din | input | 1 | Serial data, LSB first |
| ram_raddr | input | ADDR_W (6) | Display RAM read address |
| ram_rdata | output | 8 | Display RAM read data; 0 outside the window |
| grid_mode | output | 2 | Grid count minus 4 |
| disp_on | output | 1 | Display enable |
| dim_level | output | 3 | Dimming step, 0 is the narrowest pulse |
| data_cfg | output | 4 | Nibble from the last transfer setting |
| key_rd_req | output | 1 | One-cycle key-read request |

## Verification
The assertions take some things for granted about the inputs:
- Each serial-clock phase lasts longer than the synchronizer depth plus one system cycle, so every rising edge turns into exactly one capture.
- Data and strobe change only while the serial clock is low or steady.

The stimulus holds each serial phase for six system cycles. It changes data only at the start of the low phase, and moves the strobe only while the serial clock rests high. This holds for the random frames and for the aborted frames alike.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      CLS_MODE = 2'b00,
      CLS_XFER = 2'b01,
      CLS_CTRL = 2'b10,
      CLS_ADDR = 2'b11
   } cmd_cls_e;
endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ssd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= RST_VAL;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ssd_rx.sv
module ssd_rx
   import ssd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              stb_n_s,
   input  logic              din_s,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat,
   output logic              byte_first
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              sclk_q;
   logic              in_first;
   logic              rise;

   assign rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= 1'b1;
         bit_cnt    <= '0;
         shreg      <= '0;
         in_first   <= 1'b1;
         byte_vld   <= 1'b0;
         byte_dat   <= '0;
         byte_first <= 1'b0;
      end else begin
         sclk_q   <= sclk_s;
         byte_vld <= 1'b0;
         if (stb_n_s) begin
            bit_cnt  <= '0;
            in_first <= 1'b1;
         end else if (rise) begin
            shreg <= {din_s, shreg[BYTE_W-1:1]};
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
               bit_cnt    <= '0;
               byte_vld   <= 1'b1;
               byte_dat   <= {din_s, shreg[BYTE_W-1:1]};
               byte_first <= in_first;
               in_first   <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R3: a strobe seen high never lets a byte complete on the next cycle
   p_no_byte_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_n_s |=> !byte_vld);

   // R1: every completed byte follows a rising serial-clock edge
   p_byte_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(sclk_s && !sclk_q && !stb_n_s));
endmodule

// File: rtl/ssd_regs.sv
module ssd_regs
   import ssd_pkg::*;
#(
   parameter int DEPTH        = 14,
   parameter int ADDR_W       = 6,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_dat,
   input  logic              byte_first,
   input  logic [ADDR_W-1:0] ram_raddr,
   output logic [BYTE_W-1:0] ram_rdata,
   output logic [1:0]        grid_mode,
   output logic              disp_on,
   output logic [2:0]        dim_level,
   output logic [3:0]        data_cfg,
   output logic              key_rd_req
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH);

   if (ADDR_W < 4 || ADDR_W > 6) begin : g_bad_aw
      $error("ssd_regs: ADDR_W must lie in 4..6");
   end
   if (DEPTH < 2 || DEPTH >= (1 << ADDR_W)) begin : g_bad_depth
      $error("ssd_regs: DEPTH must be at least 2 and below 2**ADDR_W");
   end

   logic [BYTE_W-1:0] ram [DEPTH];
   logic [ADDR_W-1:0] wr_addr;
   logic              frame_wr;
   logic              wr_hit;
   cmd_cls_e          cls;

   assign cls    = cmd_cls_e'(byte_dat[7:6]);
   assign wr_hit = byte_vld && !byte_first && frame_wr && (wr_addr < TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grid_mode  <= 2'b11;
         disp_on    <= 1'b0;
         dim_level  <= '0;
         data_cfg   <= '0;
         key_rd_req <= 1'b0;
         wr_addr    <= '0;
         frame_wr   <= 1'b0;
      end else begin
         key_rd_req <= 1'b0;
         if (byte_vld && byte_first) begin
            frame_wr <= 1'b0;
            unique case (cls)
               CLS_MODE: if (byte_dat[5:2] == 4'd0 && byte_dat[1:0] != grid_mode) begin
                  grid_mode <= byte_dat[1:0];
                  disp_on   <= 1'b0;
               end
               CLS_XFER: if (byte_dat[5:4] == 2'd0) begin
                  data_cfg   <= byte_dat[3:0];
                  key_rd_req <= byte_dat[1];
                  frame_wr   <= !byte_dat[1];
               end
               CLS_ADDR: begin
                  wr_addr  <= byte_dat[ADDR_W-1:0];
                  frame_wr <= 1'b1;
               end
               CLS_CTRL: begin
                  disp_on   <= byte_dat[3];
                  dim_level <= byte_dat[2:0];
               end
            endcase
         end else if (wr_hit) begin
            wr_addr <= wr_addr + 1'b1;
         end
      end
   end

   if (CLEAR_ON_RST) begin : g_ram_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
         end else if (wr_hit) begin
            ram[wr_addr[IDX_W-1:0]] <= byte_dat;
         end
      end
   end else begin : g_ram_raw
      always_ff @(posedge clk) begin
         if (wr_hit) ram[wr_addr[IDX_W-1:0]] <= byte_dat;
      end
   end

   assign ram_rdata = (ram_raddr < TOP) ? ram[ram_raddr[IDX_W-1:0]] : '0;

   // R5: any change of grid mode leaves the display off
   p_mode_change_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grid_mode != $past(grid_mode)) |-> !disp_on);

   // R8: the pointer holds while it sits outside the window
   p_ptr_hold_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_first && wr_addr >= TOP) |=> $stable(wr_addr));

   // R10: the key-read request lasts a single cycle
   p_rd_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      key_rd_req |=> !key_rd_req);

   // R9: display state moves only when a byte has been decoded
   p_ctrl_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> ($stable(dim_level) && $stable(disp_on)));
endmodule

// File: rtl/strobe_cmd_decoder.sv
module strobe_cmd_decoder
   import ssd_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DEPTH        = 14,
   parameter int ADDR_W       = 6,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_stb_n,
   input  logic              ser_din,
   input  logic [ADDR_W-1:0] ram_raddr,
   output logic [7:0]        ram_rdata,
   output logic [1:0]        grid_mode,
   output logic              disp_on,
   output logic [2:0]        dim_level,
   output logic [3:0]        data_cfg,
   output logic              key_rd_req
);
   logic [2:0]        pins_s;
   logic              byte_vld;
   logic              byte_first;
   logic [BYTE_W-1:0] byte_dat;

   ssd_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_stb_n, ser_din}),
      .q     (pins_s)
   );

   ssd_rx u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (pins_s[2]),
      .stb_n_s    (pins_s[1]),
      .din_s      (pins_s[0]),
      .byte_vld   (byte_vld),
      .byte_dat   (byte_dat),
      .byte_first (byte_first)
   );

   ssd_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CLEAR_ON_RST(CLEAR_ON_RST)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_vld   (byte_vld),
      .byte_dat   (byte_dat),
      .byte_first (byte_first),
      .ram_raddr  (ram_raddr),
      .ram_rdata  (ram_rdata),
      .grid_mode  (grid_mode),
      .disp_on    (disp_on),
      .dim_level  (dim_level),
      .data_cfg   (data_cfg),
      .key_rd_req (key_rd_req)
   );
endmodule

// File: tb/strobe_cmd_decoder_tb.sv
module strobe_cmd_decoder_tb;
   localparam int AW    = 6;
   localparam int DEPTH = 14;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, ser_clk, ser_stb_n, ser_din;
   logic [AW-1:0] ram_raddr;
   logic [7:0]    ram_rdata;
   logic [1:0]    grid_mode;
   logic          disp_on;
   logic [2:0]    dim_level;
   logic [3:0]    data_cfg;
   logic          key_rd_req;

   strobe_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb_n(ser_stb_n),
      .ser_din(ser_din), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
      .grid_mode(grid_mode), .disp_on(disp_on), .dim_level(dim_level),
      .data_cfg(data_cfg), .key_rd_req(key_rd_req)
   );

   int n_chk = 0, n_fail = 0, rd_seen = 0, e_rd = 0;
   bit done = 1'b0;
   logic [7:0] e_ram [DEPTH];
   logic [1:0] e_mode;
   logic       e_on;
   logic [2:0] e_dim;
   logic [3:0] e_cfg;
   logic [5:0] e_addr;
   logic [7:0] fb [16];

   always @(posedge clk) if (rst_n && key_rd_req) rd_seen++;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 0; i < nb; i++) begin
         ser_clk = 1'b0; ser_din = b[i]; wait_clk(HALF);
         ser_clk = 1'b1; wait_clk(HALF);
      end
   endtask

   task automatic open_frame;
      ser_stb_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic close_frame;
      wait_clk(HALF); ser_stb_n = 1'b1; wait_clk(3 * HALF);
   endtask

   // expected behaviour of a frame whose first n bytes completed
   task automatic model(input int n);
      logic [7:0] c;
      bit wr;
      c = fb[0]; wr = 1'b0;
      case (c[7:6])
         2'b00: if (c[5:2] == 4'd0 && c[1:0] != e_mode) begin e_mode = c[1:0]; e_on = 1'b0; end
         2'b01: if (c[5:4] == 2'd0) begin
                   e_cfg = c[3:0];
                   if (c[1]) e_rd++; else wr = 1'b1;
                end
         2'b11: begin e_addr = c[5:0]; wr = 1'b1; end
         default: begin e_on = c[3]; e_dim = c[2:0]; end
      endcase
      for (int i = 1; i < n; i++)
         if (wr && e_addr < 6'(DEPTH)) begin e_ram[e_addr] = fb[i]; e_addr++; end
   endtask

   task automatic frame(input int n);
      open_frame();
      for (int i = 0; i < n; i++) send_bits(fb[i], 8);
      close_frame();
      model(n);
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R4 grid_mode"}, grid_mode, e_mode);
      chk({ctx, " R5 disp_on"},   disp_on,   e_on);
      chk({ctx, " R9 dim_level"}, dim_level, e_dim);
      chk({ctx, " R6 data_cfg"},  data_cfg,  e_cfg);
      chk({ctx, " R10 key_rd_req count"}, rd_seen, e_rd);
      for (int i = 0; i < DEPTH; i++) begin
         ram_raddr = AW'(i); #1;
         chk({ctx, " R7 ram byte"}, ram_rdata, e_ram[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; ser_clk = 1'b1; ser_stb_n = 1'b1; ser_din = 1'b0; ram_raddr = '0;
      e_mode = 2'd3; e_on = 1'b0; e_dim = '0; e_cfg = '0; e_addr = '0;
      for (int i = 0; i < DEPTH; i++) e_ram[i] = '0;
      wait_clk(5); rst_n = 1'b1; wait_clk(5);
      check_all("R11 reset");

      fb[0] = 8'h8D; frame(1);                 check_all("R9 control on dim5");
      fb[0] = 8'h03; frame(1);                 check_all("R5 same mode no effect");
      fb[0] = 8'h01; frame(1);                 check_all("R4 R5 mode change forces off");
      fb[0] = 8'h8A; fb[1] = 8'h55; frame(2);  check_all("R2 data after control ignored");
      fb[0] = 8'h45; frame(1);                 check_all("R6 transfer setting");

      fb[0] = 8'hC0;
      for (int i = 1; i <= DEPTH; i++) fb[i] = 8'(i * 17 + 3);
      fb[15] = 8'hEE; frame(16);               check_all("R7 R8 full burst then drop");
      fb[0] = 8'h40; fb[1] = 8'h99; frame(2);  check_all("R8 pointer stuck at 14");
      fb[0] = 8'hCD; fb[1] = 8'h3C; fb[2] = 8'h7E; frame(3);
      check_all("R7 R8 last slot then drop");
      fb[0] = 8'hCF; fb[1] = 8'h11; frame(2);  check_all("R8 address 0Fh drops");
      fb[0] = 8'hF0; fb[1] = 8'h22; frame(2);  check_all("R8 address 30h drops");

      fb[0] = 8'h42; fb[1] = 8'hA5; fb[2] = 8'h5A; frame(3);
      check_all("R10 read direction");
      fb[0] = 8'h04; frame(1);                 check_all("R12 bad mode class");
      fb[0] = 8'h50; frame(1);                 check_all("R12 bad transfer class");

      // R1: clock toggling with strobe high is ignored
      for (int i = 0; i < 11; i++) begin
         ser_clk = 1'b0; ser_din = 1'($urandom); wait_clk(HALF);
         ser_clk = 1'b1; wait_clk(HALF);
      end
      fb[0] = 8'hC6; fb[1] = 8'h81; frame(2);  check_all("R1 idle clocks ignored, LSB first");

      // R3: abort inside the command byte, then inside a data byte
      open_frame(); send_bits(8'hC3, 5); close_frame();
      fb[0] = 8'hC5; fb[1] = 8'h77; frame(2);  check_all("R3 abort in command");
      open_frame(); send_bits(8'hC2, 8); send_bits(8'hFF, 4); close_frame();
      fb[0] = 8'hC2; model(1);
      fb[0] = 8'h40; fb[1] = 8'h64; frame(2);  check_all("R3 abort in data");

      fb[0] = 8'h80; frame(1);                 check_all("R9 80h off");

      for (int k = 0; k < 60; k++) begin
         int n, r;
         n = 1 + $urandom_range(0, 5);
         r = $urandom_range(0, 9);
         case (r)
            0:       fb[0] = {6'd0, 2'($urandom)};
            1:       fb[0] = {4'b0100, 4'($urandom)};
            2, 3, 4: fb[0] = {2'b11, 6'($urandom_range(0, 17))};
            5:       fb[0] = {2'b10, 6'($urandom)};
            default: fb[0] = 8'($urandom);
         endcase
         for (int i = 1; i < n; i++) fb[i] = 8'($urandom);
         if (n > 1 && $urandom_range(0, 7) == 0) begin
            open_frame(); send_bits(fb[0], 8);
            send_bits(fb[1], $urandom_range(1, 7)); close_frame();
            model(1);
            check_all("R3 random abort");
         end else begin
            frame(n);
            check_all("R7 random frame");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule